// File: doc/BRIEF.md
# Slow-Idle Clock Enable Controller

This block manages a processor's low-power idle state. It runs on the instruction-rate base clock and never gates it. Instead it produces clock-enable strobes for the core, the serial ports and the timer, together with a clock-output square wave. While the processor runs, every strobe is high in every cycle.

An idle request moves the block into one of two idle states. The first is standard idle. There the core enable drops while the peripherals keep running at full rate, and an enabled interrupt brings the core back in the following cycle. The second is slowed idle. There the core enable and all peripheral enables fire once every n base cycles, where n is one of 16, 32, 64 or 128. An enabled interrupt in slowed idle is held until the next divided tick, and the block returns to full rate after that tick.

The idle request carries a mode bit and a 2-bit divisor code. The interrupt lines are qualified by a per-line enable mask. A disable input forces the clock output low.

Top module: `slow_idle_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `in_idle`=0, `wake`=0, `clkout`=0, and `core_en`, `sport_en` and `timer_en` all at 1.
- R2: While running (not idle), `core_en`, `sport_en` and `timer_en` are 1 in every cycle, and `clkout` (when enabled) inverts on every cycle.
- R3: Consider an `idle_req` sampled while running with `idle_slow`=0. In the next cycle it gives `in_idle`=1 and `core_en`=0, while `sport_en` and `timer_en` stay at 1 every cycle.
- R4: In standard idle, an interrupt line that is high in cycle t while its `irq_en` bit is 1 gives `in_idle`=0, `wake`=1 and `core_en`=1 in cycle t+1.
- R5: An `idle_req` with `idle_slow`=1 selects n through `idle_div`: 0 gives 16, 1 gives 32, 2 gives 64, and 3 gives 128. The divisor counter restarts from zero, so the first `core_en` pulse comes in cycle n after the request edge and every n cycles after that. `core_en` is 0 in all other cycles.
- R6: In slowed idle, `sport_en` and `timer_en` equal `core_en` in every cycle. `clkout` changes only on the edge that ends a tick cycle.
- R7: In slowed idle, an enabled interrupt does not end idle before the next tick. In the cycle after that tick, `in_idle`=0, `wake`=1 and `core_en`=1.
- R8: An interrupt line whose `irq_en` bit is 0 never ends idle.
- R9: An `idle_req` sampled while already idle changes neither the mode nor the divisor.
- R10: When `clkout_dis` is 1 at an edge, `clkout` is 0 in the following cycle.
- R11: `wake` is high for exactly one cycle per exit from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-rate base clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req | input | 1 | Idle request strobe |
| idle_slow | input | 1 | 1 = slowed idle, 0 = standard idle |
| idle_div | input | 2 | Divisor code (0:16, 1:32, 2:64, 3:128) |
| irq | input | NIRQ | Interrupt lines |
| irq_en | input | NIRQ | Per-line interrupt enable mask |
| clkout_dis | input | 1 | Forces clock output low |
| core_en | output | 1 | Core clock enable |
| sport_en | output | 1 | Serial-port clock enable |
| timer_en | output | 1 | Timer tick enable |
| clkout | output | 1 | Clock output square wave |
| in_idle | output | 1 | Idle status |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The bench pins down when the first slowed tick falls for each divisor code. A counter that is not cleared on entry, or a limit that is off by one, moves the `core_en` pulse away from cycle n.

It raises an interrupt mid-period in slowed idle. A design that wakes straight away, as standard idle does, would drop `in_idle` before the tick.

It also checks three other cases:
- A masked interrupt that is held high must not end idle. A design that ignores the mask would leave idle.
- An idle request issued during slowed idle must not change the divisor. A design that reloads it would move the tick.
- The clock output must stay frozen between ticks. A design that keeps toggling it at full rate would change it between ticks.

// File: rtl/slow_idle_ctl.sv
module slow_idle_ctl #(
  parameter int NIRQ     = 4,
  parameter int BASE_LOG = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle_req,
  input  logic            idle_slow,
  input  logic [1:0]      idle_div,
  input  logic [NIRQ-1:0] irq,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            clkout_dis,
  output logic            core_en,
  output logic            sport_en,
  output logic            timer_en,
  output logic            clkout,
  output logic            in_idle,
  output logic            wake
);
  localparam int CW = BASE_LOG + 3;

  logic          in_idle_q, slow_q, pend_q, wake_q, clk_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt_q;

  wire [CW-1:0] lim      = ((CW'(1) << BASE_LOG) << sel_q) - CW'(1);
  wire          hit      = |(irq & irq_en);
  wire          slow_act = in_idle_q & slow_q;
  wire          tick     = slow_act & (cnt_q == lim);
  wire          beat     = ~slow_act | tick;
  wire          leave    = in_idle_q & (slow_q ? (tick & (pend_q | hit)) : hit);

  assign core_en  = in_idle_q ? tick : 1'b1;
  assign sport_en = beat;
  assign timer_en = beat;
  assign clkout   = clk_q;
  assign in_idle  = in_idle_q;
  assign wake     = wake_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_idle_q <= 1'b0;
      slow_q    <= 1'b0;
      sel_q     <= 2'd0;
      pend_q    <= 1'b0;
      cnt_q     <= '0;
    end else if (!in_idle_q) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      if (idle_req) begin
        in_idle_q <= 1'b1;
        slow_q    <= idle_slow;
        sel_q     <= idle_div;
      end
    end else if (leave) begin
      in_idle_q <= 1'b0;
      pend_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (hit) pend_q <= 1'b1;
      if (slow_q) cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      wake_q <= leave;
      clk_q  <= clkout_dis ? 1'b0 : (clk_q ^ beat);
    end
  end

  a_r3_std_core_off: assert property (@(posedge clk) disable iff (rst)
    in_idle_q && !slow_q |-> !core_en && sport_en && timer_en);
  a_r4_std_wake: assert property (@(posedge clk) disable iff (rst)
    in_idle_q && !slow_q && hit |=> !in_idle_q && wake);
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    slow_act && (cnt_q != lim) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r6_same_ratio: assert property (@(posedge clk) disable iff (rst)
    slow_act |-> (sport_en == core_en) && (timer_en == core_en));
  a_r7_wait_tick: assert property (@(posedge clk) disable iff (rst)
    slow_act && !core_en |=> in_idle_q);
  a_r8_no_wake_masked: assert property (@(posedge clk) disable iff (rst)
    in_idle_q && !hit && !pend_q |=> in_idle_q);
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    in_idle_q |=> $stable(sel_q) && $stable(slow_q));
  a_r10_clkout_low: assert property (@(posedge clk) disable iff (rst)
    clkout_dis |=> !clkout);
  a_r11_wake_pulse: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);
  a_r11_wake_run: assert property (@(posedge clk) disable iff (rst)
    wake |-> !in_idle && core_en);
endmodule

// File: tb/slow_idle_ctl_tb_top.sv
module slow_idle_ctl_tb_top;
  localparam int NIRQ = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            idle_req = 1'b0, idle_slow = 1'b0, clkout_dis = 1'b0;
  logic [1:0]      idle_div = 2'd0;
  logic [NIRQ-1:0] irq = '0, irq_en = '0;
  logic            core_en, sport_en, timer_en, clkout, in_idle, wake;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  slow_idle_ctl #(.NIRQ(NIRQ), .BASE_LOG(4)) dut_i (
    .clk(clk), .rst(rst), .idle_req(idle_req), .idle_slow(idle_slow),
    .idle_div(idle_div), .irq(irq), .irq_en(irq_en), .clkout_dis(clkout_dis),
    .core_en(core_en), .sport_en(sport_en), .timer_en(timer_en),
    .clkout(clkout), .in_idle(in_idle), .wake(wake));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic enter(input logic slow, input logic [1:0] code);
    idle_req = 1'b1; idle_slow = slow; idle_div = code;
    step();
    idle_req = 1'b0;
  endtask

  task automatic leave_idle();
    irq = 4'b0001; irq_en = 4'b1111;
    for (int k = 0; k < 300 && in_idle; k++) step();
    irq = '0;
    step(); step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    chk(!in_idle && !wake && !clkout, "R1 status", {in_idle, wake, clkout}, 0);
    chk(core_en && sport_en && timer_en, "R1 enables", {core_en, sport_en, timer_en}, 7);
    rst = 1'b0;
    step();
  endtask

  task automatic t_run();
    logic prev;
    prev = clkout;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(core_en && sport_en && timer_en, "R2 enables", {core_en, sport_en, timer_en}, 7);
      chk(clkout != prev, "R2 clkout toggle", clkout, !prev);
      prev = clkout;
    end
  endtask

  task automatic t_std_idle();
    enter(1'b0, 2'd0);
    for (int k = 1; k <= 4; k++) begin
      chk(in_idle && !core_en && sport_en && timer_en, "R3 standard idle",
          {in_idle, core_en, sport_en, timer_en}, 11);
      step();
    end
    irq_en = 4'b0100; irq = 4'b0100;
    step();
    irq = '0;
    chk(!in_idle && wake && core_en, "R4 one-cycle wake", {in_idle, wake, core_en}, 3);
    step();
    chk(!wake, "R11 wake single", wake, 0);
  endtask

  task automatic t_div(input logic [1:0] code);
    int n;
    logic c0;
    n = 16 << code;
    irq = '0;
    enter(1'b1, code);
    c0 = clkout;
    for (int k = 1; k <= 2 * n; k++) begin
      chk(core_en == (k % n == 0), $sformatf("R5 tick code%0d cyc%0d", code, k),
          core_en, (k % n == 0));
      chk(sport_en == core_en && timer_en == core_en, "R6 peripheral ratio",
          {sport_en, timer_en}, core_en ? 3 : 0);
      if (k == 1 || k == n) chk(clkout == c0, "R6 clkout frozen", clkout, c0);
      if (k == n + 1) chk(clkout != c0, "R6 clkout after tick", clkout, !c0);
      step();
    end
    leave_idle();
  endtask

  task automatic t_slow_wake();
    irq_en = 4'b1111;
    enter(1'b1, 2'd0);
    for (int k = 1; k <= 16; k++) begin
      if (k == 3) irq = 4'b0010;
      if (k == 4) irq = '0;
      chk(in_idle && !wake, $sformatf("R7 held cyc%0d", k), in_idle, 1);
      step();
    end
    chk(!in_idle && wake && core_en, "R7 wake after tick", {in_idle, wake, core_en}, 3);
    step();
    chk(!wake && !in_idle, "R11 wake single slow", wake, 0);
  endtask

  task automatic t_masked();
    irq_en = 4'b0001; irq = 4'b1110;
    enter(1'b1, 2'd0);
    for (int k = 0; k < 40; k++) step();
    chk(in_idle, "R8 masked irq ignored", in_idle, 1);
    irq = '0;
    leave_idle();
  endtask

  task automatic t_ignore();
    irq = '0;
    enter(1'b1, 2'd1);
    for (int k = 1; k <= 32; k++) begin
      chk(core_en == (k == 32), $sformatf("R9 tick unchanged cyc%0d", k), core_en, k == 32);
      if (k == 5) begin idle_req = 1'b1; idle_slow = 1'b1; idle_div = 2'd0; end
      if (k == 6) idle_req = 1'b0;
      step();
    end
    leave_idle();
  endtask

  task automatic t_clkdis();
    clkout_dis = 1'b1;
    step();
    for (int k = 0; k < 3; k++) begin
      chk(!clkout, "R10 clkout held low", clkout, 0);
      step();
    end
    clkout_dis = 1'b0;
    step();
    chk(clkout, "R10 clkout resumes", clkout, 1);
  endtask

  initial begin
    step();
    t_reset();
    t_run();
    t_std_idle();
    for (int c = 0; c < 4; c++) t_div(2'(c));
    t_slow_wake();
    t_masked();
    t_ignore();
    t_clkdis();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule